// File: doc/BRIEF.md
# Single-Precision NaN Classifier and Quieter

This combinational unit looks at a 32-bit binary32 floating-point word and reports which of six kinds of value it holds: zero, normal, subnormal, infinity, quiet NaN or signaling NaN. The same word can be passed through a quieting path. When a quiet request is made and the word is a signaling NaN, that path returns a quiet NaN of the same sign and raises an invalid-operation flag. Any other word passes through unchanged.

One mode input selects the convention for the top fraction bit. In the 2008 convention a set bit marks a quiet NaN. In the legacy convention a set bit marks a signaling NaN. Both the classifier and the quieting path follow this input.

A separate path takes a second operand and picks which of the two NaNs to propagate. An arithmetic unit calls this when both of its inputs are NaNs. The unit does no arithmetic and takes no traps.

Top module: `fpn_unit`

## Requirements
- R1: `cls_a` codes op_a as follows. 0 is zero: exponent 0, fraction 0. 1 is normal: exponent neither 0 nor all ones. 2 is subnormal: exponent 0, fraction nonzero. 3 is infinity: exponent all ones, fraction 0. 4 is quiet NaN and 5 is signaling NaN: exponent all ones, fraction nonzero. The exponent is bits 30:23, the fraction is bits 22:0 and the sign is bit 31.
- R2: A NaN is signaling when `nan2008` XOR fraction bit 22 equals 1. `nan2008`=1 selects the 2008 convention, in which bit 22 clear means signaling. `nan2008`=0 selects the legacy convention, in which bit 22 set means signaling.
- R3: In the 2008 convention, quieting a signaling NaN sets bit 22 and leaves every other bit unchanged.
- R4: In the legacy convention, quieting a signaling NaN clears bit 22. If the 23-bit fraction is then zero, bit 21 is set so the result is still a NaN. All other bits are unchanged.
- R5: `invalid` is 1 exactly when `quiet_req` is 1 and op_a is a signaling NaN under the current convention.
- R6: When `quiet_req` is 0, or op_a is not a signaling NaN, `quiet_word` equals op_a and `invalid` is 0. This includes a quiet NaN.
- R7: `pick_word` returns whichever of op_a and op_b has the larger fraction field (bits 22:0) as an unsigned number. On a tie it returns op_b. The whole word is returned, sign included.
- R8: The sign bit of `quiet_word` always equals the sign bit of op_a.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 32 | Operand to classify and quiet; first NaN candidate |
| op_b | input | 32 | Second NaN candidate |
| nan2008 | input | 1 | 1 = 2008 quiet-bit convention, 0 = legacy |
| quiet_req | input | 1 | Request to quiet op_a |
| cls_a | output | 3 | Class code of op_a |
| quiet_word | output | 32 | op_a, quieted if requested and signaling |
| invalid | output | 1 | Invalid-operation flag from quieting |
| pick_word | output | 32 | NaN chosen for propagation |

## Verification
The same word 0x7FC00000 is classified under both conventions. A design with the XOR inverted would swap quiet and signaling in both modes. The legacy signaling NaN whose only set fraction bit is bit 22 is the key quieting case. A design that skips the bit-21 repair would return infinity instead of a NaN. The selector is given equal fractions with opposite signs, and a sign bit that must not enter the comparison. A design that compares whole words, or that prefers op_a on a tie, returns the wrong operand. A quiet NaN sent with the quiet request set checks that no flag is raised and the word is left alone.

// File: rtl/fpn_pkg.sv
package fpn_pkg;

    localparam int SP_EXP_W  = 8;
    localparam int SP_FRAC_W = 23;

    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_NORM = 3'd1,
        CLS_SUB  = 3'd2,
        CLS_INF  = 3'd3,
        CLS_QNAN = 3'd4,
        CLS_SNAN = 3'd5
    } fp_cls_e;

    // Signaling when the convention bit differs from the top fraction bit.
    function automatic logic nan_signals(input logic mode2008, input logic top_frac);
        return mode2008 ^ top_frac;
    endfunction

endpackage

// File: rtl/fpn_classify.sv
module fpn_classify
    import fpn_pkg::*;
#(
    parameter int EXP_W  = SP_EXP_W,
    parameter int FRAC_W = SP_FRAC_W,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic [WORD_W-1:0] word,
    input  logic              mode2008,
    output fp_cls_e           cls
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    assign exp_f  = word[WORD_W-2 -: EXP_W];
    assign frac_f = word[FRAC_W-1:0];

    always_comb begin
        if (exp_f == '0)
            cls = (frac_f == '0) ? CLS_ZERO : CLS_SUB;
        else if (exp_f != '1)
            cls = CLS_NORM;
        else if (frac_f == '0)
            cls = CLS_INF;
        else if (nan_signals(mode2008, frac_f[FRAC_W-1]))
            cls = CLS_SNAN;
        else
            cls = CLS_QNAN;
    end
endmodule

// File: rtl/fpn_quiet.sv
module fpn_quiet
    import fpn_pkg::*;
#(
    parameter int EXP_W  = SP_EXP_W,
    parameter int FRAC_W = SP_FRAC_W,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic [WORD_W-1:0] word,
    input  fp_cls_e           cls,
    input  logic              mode2008,
    input  logic              req,
    output logic [WORD_W-1:0] quiet_word,
    output logic              invalid
);
    logic [FRAC_W-1:0] frac_new;
    logic [FRAC_W-1:0] frac_cleared;

    always_comb begin
        frac_cleared = word[FRAC_W-1:0];
        frac_cleared[FRAC_W-1] = 1'b0;
        if (mode2008) begin
            frac_new = word[FRAC_W-1:0];
            frac_new[FRAC_W-1] = 1'b1;
        end else begin
            frac_new = frac_cleared;
            if (frac_cleared == '0)
                frac_new[FRAC_W-2] = 1'b1;
        end
    end

    always_comb begin
        invalid    = req && (cls == CLS_SNAN);
        quiet_word = invalid ? {word[WORD_W-1:FRAC_W], frac_new} : word;
    end
endmodule

// File: rtl/fpn_select.sv
module fpn_select
    import fpn_pkg::*;
#(
    parameter int EXP_W  = SP_EXP_W,
    parameter int FRAC_W = SP_FRAC_W,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output logic [WORD_W-1:0] pick
);
    logic a_wins;

    assign a_wins = a[FRAC_W-1:0] > b[FRAC_W-1:0];
    assign pick   = a_wins ? a : b;
endmodule

// File: rtl/fpn_unit.sv
module fpn_unit
    import fpn_pkg::*;
#(
    parameter int EXP_W  = SP_EXP_W,
    parameter int FRAC_W = SP_FRAC_W,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic              nan2008,
    input  logic              quiet_req,
    output logic [2:0]        cls_a,
    output logic [WORD_W-1:0] quiet_word,
    output logic              invalid,
    output logic [WORD_W-1:0] pick_word
);
    fp_cls_e cls_in;
    fp_cls_e cls_out;

    fpn_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_in (
        .word(op_a), .mode2008(nan2008), .cls(cls_in)
    );

    fpn_quiet #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_quiet (
        .word(op_a), .cls(cls_in), .mode2008(nan2008), .req(quiet_req),
        .quiet_word(quiet_word), .invalid(invalid)
    );

    fpn_select #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_sel (
        .a(op_a), .b(op_b), .pick(pick_word)
    );

    // Reclassify the quieting result so it can be checked against the input class.
    fpn_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_out (
        .word(quiet_word), .mode2008(nan2008), .cls(cls_out)
    );

    assign cls_a = cls_in;

    always_comb begin
        a_r3_quieted_is_qnan: assert (!invalid || cls_out == CLS_QNAN)
            else $error("quieted word is not a quiet NaN");
        a_r6_passthrough: assert (invalid || quiet_word == op_a)
            else $error("word altered without invalid flag");
        a_r8_sign_kept: assert (quiet_word[WORD_W-1] == op_a[WORD_W-1])
            else $error("sign changed by quieting");
        a_r7_pick_member: assert (pick_word == op_a || pick_word == op_b)
            else $error("picked word is neither operand");
        a_r5_flag_snan: assert (!invalid || (quiet_req && cls_in == CLS_SNAN))
            else $error("invalid raised for a non-signaling operand");
    end
endmodule

// File: tb/fpn_unit_test.sv
module fpn_unit_test;
    logic        clk = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic        nan2008 = 1'b1, quiet_req = 1'b0;
    logic [2:0]  cls_a;
    logic [31:0] quiet_word, pick_word;
    logic        invalid;
    int          n_vec = 0, n_bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    fpn_unit uut (
        .op_a(op_a), .op_b(op_b), .nan2008(nan2008), .quiet_req(quiet_req),
        .cls_a(cls_a), .quiet_word(quiet_word), .invalid(invalid), .pick_word(pick_word)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic m, input logic q);
        @(negedge clk);
        op_a = a; op_b = b; nan2008 = m; quiet_req = q;
        #3;
    endtask

    task automatic t_idle;
        apply(32'h0, 32'h0, 1'b1, 1'b0);
        chk("R1 zero at start", {29'd0, cls_a}, 32'd0);
        chk("R6 no flag at start", {31'd0, invalid}, 32'd0);
    endtask

    task automatic t_classes;
        apply(32'h8000_0000, 0, 1, 0); chk("R1 neg zero", {29'd0, cls_a}, 0);
        apply(32'h3F80_0000, 0, 1, 0); chk("R1 normal", {29'd0, cls_a}, 1);
        apply(32'h0000_0001, 0, 1, 0); chk("R1 subnormal", {29'd0, cls_a}, 2);
        apply(32'hFF80_0000, 0, 0, 0); chk("R1 infinity", {29'd0, cls_a}, 3);
    endtask

    task automatic t_convention;
        apply(32'h7FC0_0000, 0, 1, 0); chk("R2 2008 qnan", {29'd0, cls_a}, 4);
        apply(32'h7FC0_0000, 0, 0, 0); chk("R2 legacy snan", {29'd0, cls_a}, 5);
        apply(32'h7F80_0001, 0, 1, 0); chk("R2 2008 snan", {29'd0, cls_a}, 5);
        apply(32'h7F80_0001, 0, 0, 0); chk("R2 legacy qnan", {29'd0, cls_a}, 4);
    endtask

    task automatic t_quiet2008;
        apply(32'h7F80_0001, 0, 1, 1);
        chk("R3 2008 quiet", quiet_word, 32'h7FC0_0001);
        chk("R5 flag 2008", {31'd0, invalid}, 1);
        apply(32'hFF81_2345, 0, 1, 1);
        chk("R8 sign kept 2008", quiet_word, 32'hFFC1_2345);
    endtask

    task automatic t_quiet_legacy;
        apply(32'h7FC0_0000, 0, 0, 1);
        chk("R4 legacy repair", quiet_word, 32'h7FA0_0000);
        chk("R5 flag legacy", {31'd0, invalid}, 1);
        apply(32'hFFC0_0001, 0, 0, 1);
        chk("R4 legacy clear R8", quiet_word, 32'hFF80_0001);
    endtask

    task automatic t_passthrough;
        apply(32'h7FC0_0007, 0, 1, 1);
        chk("R6 qnan untouched", quiet_word, 32'h7FC0_0007);
        chk("R6 qnan no flag", {31'd0, invalid}, 0);
        apply(32'h7F80_0001, 0, 1, 0);
        chk("R6 no request", quiet_word, 32'h7F80_0001);
        chk("R5 no request no flag", {31'd0, invalid}, 0);
        apply(32'h3F80_0000, 0, 0, 1);
        chk("R5 normal no flag", {31'd0, invalid}, 0);
    endtask

    task automatic t_pick;
        apply(32'h7FC0_0005, 32'h7FC0_0003, 1, 0);
        chk("R7 a larger", pick_word, 32'h7FC0_0005);
        apply(32'hFF80_0010, 32'h7F80_0010, 1, 0);
        chk("R7 tie gives b", pick_word, 32'h7F80_0010);
        apply(32'h7F80_0001, 32'hFFFF_FFFF, 1, 0);
        chk("R7 b larger", pick_word, 32'hFFFF_FFFF);
        apply(32'hFF80_0002, 32'h7F80_0001, 0, 0);
        chk("R7 sign ignored", pick_word, 32'hFF80_0002);
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        t_idle();
        t_classes();
        t_convention();
        t_quiet2008();
        t_quiet_legacy();
        t_passthrough();
        t_pick();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule